// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block keeps the volatile position of a 64-tap digitally controlled resistor divider and turns it into a one-hot tap-select bus for the switch array. The position can change in four ways: a recall of stored register 0 after power-up, a direct value written over the serial link, a parallel copy of one of four stored data registers, and single-step moves issued while an increment/decrement command is open.

A step moves the position by one. The serial input level sampled on each serial-clock pulse gives the direction: a high level moves toward the high terminal and a low level moves toward the low terminal. Steps stop at either end of the range and never wrap. When more than one source requests in the same cycle, a fixed priority decides which one updates the register. The current position is also returned, zero-extended to a byte, for the read-wiper command.

Top module: `wiper_pos_reg`

## Requirements
- R1: After reset the position is 0, tap select bit 0 is the only bit set, and the readback byte is 0x00.
- R2: In every cycle exactly one of the 64 tap-select bits is set, and its index equals the position. Index 0 is the low terminal and index 63 is the high terminal.
- R3: A recall request loads the recall value into the position on the next clock edge. It takes priority over every other source in the same cycle.
- R4: A direct write loads its value on the next clock edge. It takes priority over a transfer and over a step.
- R5: A transfer loads stored entry k, selected by the 2-bit select, from bits [6k+5:6k] of the bank bus on the next clock edge. It takes priority over a step.
- R6: While stepping is enabled, a step pulse with direction 1 adds one to the position and a step pulse with direction 0 subtracts one.
- R7: An up step at 63 leaves the position at 63, and a down step at 0 leaves it at 0.
- R8: A step pulse while stepping is disabled has no effect. With no request at all, the position holds.
- R9: The readback byte equals {2'b00, position}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recall_req_i | input | 1 | Power-up recall strobe |
| recall_val_i | input | 6 | Contents of stored register 0 |
| wr_req_i | input | 1 | Direct write strobe |
| wr_val_i | input | 6 | Direct write value |
| xfer_req_i | input | 1 | Transfer-from-bank strobe |
| xfer_sel_i | input | 2 | Bank entry to copy |
| bank_i | input | 24 | Four stored 6-bit entries, entry k at bits [6k+5:6k] |
| step_en_i | input | 1 | Increment/decrement command is open |
| step_pulse_i | input | 1 | One-cycle pulse per serial-clock step |
| step_up_i | input | 1 | Step direction, 1 = toward high terminal |
| pos_o | output | 6 | Current position |
| tap_sel_o | output | 64 | One-hot tap select |
| rdback_o | output | 8 | Zero-extended position for readback |

## Verification
The checker watches the tap bus on every cycle: one bit set, end taps tied to the end positions, readback upper bits clear. It also checks the one-cycle effect of recall, direct write and single steps, the hold when nothing is requested, and the saturation at both ends. Which bank entry a transfer picks, and the order of a four-way conflict resolved to a specific value, can only be shown by the bench. The bench drives chosen bank contents and overlapping requests and compares the result against its own model.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_RECALL = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_STEP   = 2'd3
    } wpr_src_e;
endpackage

// File: rtl/wpr_load_mux.sv
module wpr_load_mux #(
    parameter int POS_W  = 6,
    parameter int N_BANK = 4,
    localparam int SEL_W = $clog2(N_BANK)
) (
    input  logic                    wr_req_i,
    input  logic [POS_W-1:0]        wr_val_i,
    input  logic                    xfer_req_i,
    input  logic [SEL_W-1:0]        xfer_sel_i,
    input  logic [N_BANK*POS_W-1:0] bank_i,
    output logic                    load_req_o,
    output logic [POS_W-1:0]        load_val_o
);
    logic [POS_W-1:0] bank_pick;

    always_comb begin
        bank_pick = bank_i[xfer_sel_i*POS_W +: POS_W];
    end

    always_comb begin
        load_req_o = wr_req_i | xfer_req_i;
        // direct write outranks the bank transfer
        load_val_o = wr_req_i ? wr_val_i : bank_pick;
    end
endmodule

// File: rtl/wpr_step.sv
module wpr_step #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic             up_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] BOT = '0;

    always_comb begin
        if (up_i) begin
            pos_o = (pos_i == TOP) ? TOP : pos_i + POS_W'(1);
        end else begin
            pos_o = (pos_i == BOT) ? BOT : pos_i - POS_W'(1);
        end
    end
endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  sel_o
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign sel_o[t] = (pos_i == POS_W'(t));
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg #(
    parameter int POS_W  = 6,
    parameter int N_BANK = 4,
    parameter int RB_W   = 8,
    localparam int SEL_W = $clog2(N_BANK),
    localparam int TAPS  = 1 << POS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    recall_req_i,
    input  logic [POS_W-1:0]        recall_val_i,
    input  logic                    wr_req_i,
    input  logic [POS_W-1:0]        wr_val_i,
    input  logic                    xfer_req_i,
    input  logic [SEL_W-1:0]        xfer_sel_i,
    input  logic [N_BANK*POS_W-1:0] bank_i,
    input  logic                    step_en_i,
    input  logic                    step_pulse_i,
    input  logic                    step_up_i,
    output logic [POS_W-1:0]        pos_o,
    output logic [TAPS-1:0]         tap_sel_o,
    output logic [RB_W-1:0]         rdback_o
);
    import wpr_pkg::*;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } wpr_state_t;

    wpr_state_t       st_d, st_q;
    wpr_src_e         src;
    logic             load_req;
    logic [POS_W-1:0] load_val;
    logic [POS_W-1:0] step_val;

    wpr_load_mux #(.POS_W(POS_W), .N_BANK(N_BANK)) u_load (
        .wr_req_i   (wr_req_i),
        .wr_val_i   (wr_val_i),
        .xfer_req_i (xfer_req_i),
        .xfer_sel_i (xfer_sel_i),
        .bank_i     (bank_i),
        .load_req_o (load_req),
        .load_val_o (load_val)
    );

    wpr_step #(.POS_W(POS_W)) u_step (
        .pos_i (st_q.pos),
        .up_i  (step_up_i),
        .pos_o (step_val)
    );

    wpr_tap_decode #(.POS_W(POS_W)) u_dec (
        .pos_i (st_q.pos),
        .sel_o (tap_sel_o)
    );

    always_comb begin
        st_d = st_q;
        if (recall_req_i) begin
            src = SRC_RECALL;
        end else if (load_req) begin
            src = SRC_LOAD;
        end else if (step_en_i && step_pulse_i) begin
            src = SRC_STEP;
        end else begin
            src = SRC_HOLD;
        end
        case (src)
            SRC_RECALL: st_d.pos = recall_val_i;
            SRC_LOAD:   st_d.pos = load_val;
            SRC_STEP:   st_d.pos = step_val;
            default:    st_d.pos = st_q.pos;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o    = st_q.pos;
    assign rdback_o = RB_W'(st_q.pos);
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
    parameter int POS_W  = 6,
    parameter int RB_W   = 8,
    localparam int TAPS  = 1 << POS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             recall_req_i,
    input logic [POS_W-1:0] recall_val_i,
    input logic             wr_req_i,
    input logic [POS_W-1:0] wr_val_i,
    input logic             xfer_req_i,
    input logic             step_en_i,
    input logic             step_pulse_i,
    input logic             step_up_i,
    input logic [POS_W-1:0] pos_o,
    input logic [TAPS-1:0]  tap_sel_o,
    input logic [RB_W-1:0]  rdback_o
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic stepping, quiet;
    assign stepping = step_en_i && step_pulse_i && !recall_req_i && !wr_req_i && !xfer_req_i;
    assign quiet    = !recall_req_i && !wr_req_i && !xfer_req_i && !(step_en_i && step_pulse_i);

    p_one_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1);

    p_low_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel_o[0] == (pos_o == '0));

    p_high_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel_o[TAPS-1] == (pos_o == TOP));

    p_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req_i |=> pos_o == $past(recall_val_i));

    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !recall_req_i) |=> pos_o == $past(wr_val_i));

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && step_up_i && pos_o != TOP) |=> pos_o == $past(pos_o) + POS_W'(1));

    p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !step_up_i && pos_o != '0) |=> pos_o == $past(pos_o) - POS_W'(1));

    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && step_up_i && pos_o == TOP) |=> pos_o == TOP);

    p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !step_up_i && pos_o == '0) |=> pos_o == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(pos_o));

    p_rb_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdback_o[RB_W-1:POS_W] == '0 && rdback_o[POS_W-1:0] == pos_o);
endmodule

bind wiper_pos_reg wpr_checker #(.POS_W(POS_W), .RB_W(RB_W)) u_wpr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .recall_req_i (recall_req_i),
    .recall_val_i (recall_val_i),
    .wr_req_i     (wr_req_i),
    .wr_val_i     (wr_val_i),
    .xfer_req_i   (xfer_req_i),
    .step_en_i    (step_en_i),
    .step_pulse_i (step_pulse_i),
    .step_up_i    (step_up_i),
    .pos_o        (pos_o),
    .tap_sel_o    (tap_sel_o),
    .rdback_o     (rdback_o)
);

// File: tb/wiper_pos_reg_bench.sv
module wiper_pos_reg_bench;
    localparam int POS_W = 6;
    localparam int TAPS  = 64;

    typedef struct {
        logic [POS_W-1:0] pos;
        string            req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall_req = 1'b0;
    logic [5:0]  recall_val = '0;
    logic        wr_req = 1'b0;
    logic [5:0]  wr_val = '0;
    logic        xfer_req = 1'b0;
    logic [1:0]  xfer_sel = '0;
    logic [23:0] bank = '0;
    logic        step_en = 1'b0;
    logic        step_pulse = 1'b0;
    logic        step_up = 1'b0;
    logic [5:0]  pos;
    logic [63:0] tap_sel;
    logic [7:0]  rdback;

    int   n_vec = 0;
    int   n_bad = 0;
    logic [5:0] mpos = '0;
    exp_t q[$];
    bit   done = 1'b0;

    always #10 clk = ~clk;

    wiper_pos_reg u_wiper_pos_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .recall_req_i (recall_req),
        .recall_val_i (recall_val),
        .wr_req_i     (wr_req),
        .wr_val_i     (wr_val),
        .xfer_req_i   (xfer_req),
        .xfer_sel_i   (xfer_sel),
        .bank_i       (bank),
        .step_en_i    (step_en),
        .step_pulse_i (step_pulse),
        .step_up_i    (step_up),
        .pos_o        (pos),
        .tap_sel_o    (tap_sel),
        .rdback_o     (rdback)
    );

    function automatic void compare(logic [5:0] e, string req);
        logic [63:0] etap;
        etap = 64'd1 << e;
        n_vec++;
        if (pos !== e || tap_sel !== etap || rdback !== {2'b00, e}) begin
            n_bad++;
            $display("FAIL %s: pos=%0d tap=%h rb=%h expected pos=%0d tap=%h rb=%h",
                     req, pos, tap_sel, rdback, e, etap, {2'b00, e});
        end
    endfunction

    // driver: one cycle of stimulus, model computes the expected position
    task automatic apply(input bit rc, input logic [5:0] rcv, input bit wr, input logic [5:0] wrv,
                         input bit xf, input logic [1:0] xs, input bit se, input bit sp,
                         input bit su, input string req);
        exp_t it;
        @(negedge clk);
        recall_req = rc; recall_val = rcv; wr_req = wr; wr_val = wrv;
        xfer_req = xf; xfer_sel = xs; step_en = se; step_pulse = sp; step_up = su;
        if (rc)                mpos = rcv;
        else if (wr)           mpos = wrv;
        else if (xf)           mpos = bank[xs*6 +: 6];
        else if (se && sp) begin
            if (su) mpos = (mpos == 6'd63) ? 6'd63 : mpos + 6'd1;
            else    mpos = (mpos == 6'd0)  ? 6'd0  : mpos - 6'd1;
        end
        it.pos = mpos; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input string req);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    // monitor: result of the edge just passed
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                compare(it.pos, it.req);
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: pos=%0d expected run completion", pos);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bank = {6'd50, 6'd33, 6'd17, 6'd5};   // entries 3,2,1,0
        repeat (3) @(negedge clk);
        compare(6'd0, "R1 reset");
        rst_n = 1'b1;
        idle("R8 hold after reset");

        // R3 recall of stored register 0 value
        apply(1, 6'h2A, 0, 0, 0, 0, 0, 0, 0, "R3 recall");
        idle("R9 readback 0x2A");
        // R3 recall beats every other source
        apply(1, 6'd9, 1, 6'd40, 1, 2'd3, 1, 1, 1, "R3 recall priority");
        // R4 write beats transfer and step
        apply(0, 0, 1, 6'd62, 1, 2'd1, 1, 1, 0, "R4 write priority");
        // R6 step up, R7 saturation at top
        apply(0, 0, 0, 0, 0, 0, 1, 1, 1, "R6 step up to 63");
        apply(0, 0, 0, 0, 0, 0, 1, 1, 1, "R7 saturate top");
        apply(0, 0, 0, 0, 0, 0, 1, 1, 1, "R7 saturate top again");
        // R6 step down
        apply(0, 0, 0, 0, 0, 0, 1, 1, 0, "R6 step down");
        // R8 pulse without enable and enable without pulse
        apply(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 step disabled");
        apply(0, 0, 0, 0, 0, 0, 1, 0, 1, "R8 no pulse");
        // R5 transfer of each entry, and transfer beating a step
        for (int k = 0; k < 4; k++) begin
            apply(0, 0, 0, 0, 1, 2'(k), 0, 0, 0, "R5 transfer entry");
        end
        apply(0, 0, 0, 0, 1, 2'd1, 1, 1, 1, "R5 transfer priority");
        // R7 walk down to 0 and saturate
        apply(0, 0, 1, 6'd2, 0, 0, 0, 0, 0, "R4 write 2");
        for (int k = 0; k < 4; k++) begin
            apply(0, 0, 0, 0, 0, 0, 1, 1, 0, "R7 step down to bottom");
        end
        // R2 walk the whole range upward, every tap seen
        for (int k = 0; k < 64; k++) begin
            apply(0, 0, 0, 0, 0, 0, 1, 1, 1, "R2 tap walk");
        end
        idle("R8 hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule